// File: doc/BRIEF.md
# Floating-Point Special-Operand Resolver

This block sits in front of a binary32/binary64 arithmetic datapath and decides, one clock after an operation is presented, whether the operands alone fix the answer. Any NaN operand, an undefined combination such as infinity minus infinity, or a zero-times-zero accumulate with a known sign all count as special operands. When it raises `special_o`, `result_o` holds the final bit pattern and `invalid_o` says whether the invalid-operation exception applies. When `special_o` is low, the arithmetic unit downstream computes the value. Maximum and minimum (plain and number-preferring) are always resolved here, including signed zeros.

Operands arrive as raw bit patterns on three 64-bit ports. In binary32 mode (`dbl_i` = 0) only bits 31:0 of each operand are used, and the upper 32 result bits are zero. For the fused forms, `src_a_i` is the multiplicand, `src_b_i` the multiplier and `src_c_i` the addend. The negated fused forms flip the sign bits of the multiplicand and/or addend before any other processing.

Top module: `fp_special_resolver`

## Requirements
- R1: After reset `out_valid`, `special_o` and `invalid_o` are 0. Each operation presented with `in_valid` = 1 produces `out_valid` = 1 with its result exactly one clock later, and an idle cycle gives `out_valid` = 0.
- R2: For add (op 0), sub (1), mul (2), div (3), max (5), min (6), the first signalling NaN in the order A then B is returned. If there is none, the first quiet NaN in the order A then B is returned. The returned NaN is quieted by setting fraction bit 22 (binary32) or bit 51 (binary64).
- R3: For fused ops (9: C+A·B, 10: C−A·B, 11: −C−A·B, 12: −C+A·B), NaN priority is signalling in C, A, B, then quiet in C, A, B.
- R4: With `dn_mode_i` = 1, every NaN result is the default NaN: 0x7FC00000 (binary32) or 0x7FF8000000000000 (binary64).
- R5: The following give the default NaN with invalid set: add of opposite-signed infinities, sub of like-signed infinities, mul of infinity by zero, div of infinity by infinity, and div of zero by zero.
- R6: Sqrt (op 4, operand A) of a negative non-zero, non-NaN value gives the default NaN with invalid set. Sqrt of a NaN gives the processed NaN. Sqrt of −0 is not special.
- R7: A fused op whose product is infinity times zero, or whose infinite addend meets an infinite product of opposite sign, gives the default NaN with invalid set. This also holds when the addend is a quiet NaN.
- R8: For maxnm (op 7) and minnm (op 8), a quiet NaN paired with a non-NaN is replaced by −infinity (maxnm) or +infinity (minnm) before comparing. Signalling NaNs and two quiet NaNs propagate as in R2.
- R9: Max and min with no NaN input are always special and return the larger or smaller operand. Max of +0 and −0 is +0, and min of them is −0, in either operand order.
- R10: A fused op with a zero product and a zero addend (no NaN, no infinity) is special and returns −0 only when both the effective addend and the product are negative, otherwise +0.
- R11: `invalid_o` is 1 exactly when a signalling NaN among the used operands decides the result or a default NaN is generated. Propagated quiet NaNs and resolved values give 0.
- R12: In binary32 mode the upper 32 bits of every operand are ignored and the upper 32 result bits are 0.
- R13: Negated fused forms apply their sign flips before resolution, so a NaN propagated from a flipped operand carries the flipped sign.
- R14: When the operands do not fix the result, `special_o`, `invalid_o` and `result_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation presented this cycle |
| op_i | input | 4 | Operation code (see requirements) |
| dbl_i | input | 1 | 1 = binary64, 0 = binary32 |
| dn_mode_i | input | 1 | Default-NaN mode |
| src_a_i | input | 64 | Operand A / multiplicand |
| src_b_i | input | 64 | Operand B / multiplier |
| src_c_i | input | 64 | Addend for fused ops |
| out_valid | output | 1 | Result valid |
| special_o | output | 1 | Result fixed by special operands |
| result_o | output | 64 | Resolved result pattern |
| invalid_o | output | 1 | Invalid-operation indication |

## Verification
The hardest situation to reach is the one where a generated NaN has to beat a quiet NaN coming from the addend. This needs a fused op whose multiplicand and multiplier form infinity times zero while the addend is a quiet NaN. A second hard case is the sign of a NaN after a negated fused form flips it. Directed transactions build both cases exactly, with hand-computed results. A long pseudo-random phase then draws every operand from a pool of zeros, infinities, quiet and signalling NaNs with payloads, and ordinary values. It covers all op codes, both precisions and both NaN modes, and compares each clock against a behavioural reference.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int DW      = 64;
  localparam int SP_W    = 32;
  localparam int SP_FRAC = 23;
  localparam int DP_FRAC = 52;
  localparam int OP_W    = 4;
  localparam int NSRC    = 3;
  localparam int IW      = $clog2(NSRC);

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0, OP_SUB = 4'd1, OP_MUL = 4'd2, OP_DIV = 4'd3,
    OP_SQRT = 4'd4, OP_MAX = 4'd5, OP_MIN = 4'd6, OP_MAXNM = 4'd7,
    OP_MINNM = 4'd8, OP_FMA = 4'd9, OP_FMS = 4'd10, OP_FNMA = 4'd11,
    OP_FNMS = 4'd12
  } fpsr_op_e;

  typedef struct packed {
    logic sign;
    logic zero;
    logic inf;
    logic nan;
    logic snan;
  } fpsr_cls_t;

  function automatic logic [DW-1:0] sign_bit(input logic dbl);
    return dbl ? (DW'(1) << (DW-1)) : (DW'(1) << (SP_W-1));
  endfunction

  function automatic logic [DW-1:0] quiet_bit(input logic dbl);
    return dbl ? (DW'(1) << (DP_FRAC-1)) : (DW'(1) << (SP_FRAC-1));
  endfunction

  function automatic logic [DW-1:0] inf_pat(input logic dbl, input logic neg);
    logic [DW-1:0] mag;
    mag = dbl ? ((DW'(1) << (DW-1)) - (DW'(1) << DP_FRAC))
              : ((DW'(1) << (SP_W-1)) - (DW'(1) << SP_FRAC));
    return neg ? (mag | sign_bit(dbl)) : mag;
  endfunction

  function automatic logic [DW-1:0] default_nan(input logic dbl);
    return inf_pat(dbl, 1'b0) | quiet_bit(dbl);
  endfunction
endpackage

// File: rtl/fpsr_classify.sv
module fpsr_classify
  import fpsr_pkg::*;
(
  input  logic            dbl,
  input  logic [DW-1:0]   val,
  output fpsr_cls_t       cls
);
  logic exp_ones, exp_zero, frac_zero, qbit;

  always_comb begin
    if (dbl) begin
      exp_ones  = &val[DW-2:DP_FRAC];
      exp_zero  = ~|val[DW-2:DP_FRAC];
      frac_zero = ~|val[DP_FRAC-1:0];
      qbit      = val[DP_FRAC-1];
      cls.sign  = val[DW-1];
    end else begin
      exp_ones  = &val[SP_W-2:SP_FRAC];
      exp_zero  = ~|val[SP_W-2:SP_FRAC];
      frac_zero = ~|val[SP_FRAC-1:0];
      qbit      = val[SP_FRAC-1];
      cls.sign  = val[SP_W-1];
    end
    cls.zero = exp_zero & frac_zero;
    cls.inf  = exp_ones & frac_zero;
    cls.nan  = exp_ones & ~frac_zero;
    cls.snan = exp_ones & ~frac_zero & ~qbit;
  end
endmodule

// File: rtl/fpsr_nan_pick.sv
module fpsr_nan_pick
  import fpsr_pkg::*;
(
  input  fpsr_cls_t [NSRC-1:0] cls,
  input  logic [NSRC-1:0]      en,
  output logic                 found,
  output logic                 snan_any,
  output logic [IW-1:0]        sel
);
  always_comb begin
    found    = 1'b0;
    snan_any = 1'b0;
    sel      = '0;
    for (int i = NSRC-1; i >= 0; i--) begin
      if (en[i] && cls[i].nan) begin
        found = 1'b1;
        sel   = IW'(i);
      end
    end
    for (int i = NSRC-1; i >= 0; i--) begin
      if (en[i] && cls[i].snan) begin
        snan_any = 1'b1;
        sel      = IW'(i);
      end
    end
  end
endmodule

// File: rtl/fpsr_minmax.sv
module fpsr_minmax
  import fpsr_pkg::*;
(
  input  logic          dbl,
  input  logic          is_max,
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  output logic [DW-1:0] res
);
  logic          sx, sy, x_lt_y, y_lt_x;
  logic [DW-2:0] mx, my;

  always_comb begin
    sx = dbl ? x[DW-1] : x[SP_W-1];
    sy = dbl ? y[DW-1] : y[SP_W-1];
    mx = dbl ? x[DW-2:0] : (DW-1)'(x[SP_W-2:0]);
    my = dbl ? y[DW-2:0] : (DW-1)'(y[SP_W-2:0]);
    if (sx != sy) begin
      x_lt_y = sx;
      y_lt_x = sy;
    end else if (sx) begin
      x_lt_y = mx > my;
      y_lt_x = my > mx;
    end else begin
      x_lt_y = mx < my;
      y_lt_x = my < mx;
    end
    if (is_max) res = x_lt_y ? y : x;
    else        res = y_lt_x ? y : x;
  end
endmodule

// File: rtl/fp_special_resolver.sv
module fp_special_resolver
  import fpsr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [OP_W-1:0] op_i,
  input  logic            dbl_i,
  input  logic            dn_mode_i,
  input  logic [DW-1:0]   src_a_i,
  input  logic [DW-1:0]   src_b_i,
  input  logic [DW-1:0]   src_c_i,
  output logic            out_valid,
  output logic            special_o,
  output logic [DW-1:0]   result_o,
  output logic            invalid_o
);
  // reset synchronizer: assert async, release on clock
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  fpsr_op_e op;
  logic is_fused, neg_a, neg_c, is_nm, is_mm;
  logic [DW-1:0] lo_mask;
  logic [NSRC-1:0][DW-1:0] src;
  fpsr_cls_t [NSRC-1:0] cls;

  always_comb begin
    op       = fpsr_op_e'(op_i);
    is_fused = (op == OP_FMA) || (op == OP_FMS) || (op == OP_FNMA) || (op == OP_FNMS);
    neg_a    = (op == OP_FMS) || (op == OP_FNMA);
    neg_c    = (op == OP_FNMA) || (op == OP_FNMS);
    is_nm    = (op == OP_MAXNM) || (op == OP_MINNM);
    is_mm    = is_nm || (op == OP_MAX) || (op == OP_MIN);
    lo_mask  = dbl_i ? '1 : DW'({SP_W{1'b1}});
    src[0]   = (src_a_i & lo_mask) ^ (neg_a ? sign_bit(dbl_i) : '0);
    src[1]   = src_b_i & lo_mask;
    src[2]   = (src_c_i & lo_mask) ^ (neg_c ? sign_bit(dbl_i) : '0);
  end

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_cls
    fpsr_classify u_cls (.dbl(dbl_i), .val(src[gi]), .cls(cls[gi]));
  end

  // priority order: fused ops check the addend first
  logic [NSRC-1:0][DW-1:0] ord_val;
  fpsr_cls_t [NSRC-1:0]    ord_cls;
  logic [NSRC-1:0]         ord_en;

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      ord_val[i] = is_fused ? src[(i + NSRC - 1) % NSRC] : src[i];
      ord_cls[i] = is_fused ? cls[(i + NSRC - 1) % NSRC] : cls[i];
    end
    if (is_fused)          ord_en = '1;
    else if (op == OP_SQRT) ord_en = NSRC'(1);
    else                   ord_en = NSRC'(3);
  end

  logic          nan_found, snan_any;
  logic [IW-1:0] nan_sel;

  fpsr_nan_pick u_pick (
    .cls(ord_cls), .en(ord_en),
    .found(nan_found), .snan_any(snan_any), .sel(nan_sel)
  );

  // number-preferring substitution of a lone quiet NaN
  logic          a_qlone, b_qlone, nm_sub;
  logic [DW-1:0] mm_x, mm_y, mm_res;

  always_comb begin
    a_qlone = cls[0].nan & ~cls[0].snan & ~cls[1].nan;
    b_qlone = cls[1].nan & ~cls[1].snan & ~cls[0].nan;
    nm_sub  = is_nm & (a_qlone | b_qlone);
    mm_x    = (is_nm & a_qlone) ? inf_pat(dbl_i, op == OP_MAXNM) : src[0];
    mm_y    = (is_nm & b_qlone) ? inf_pat(dbl_i, op == OP_MAXNM) : src[1];
  end

  fpsr_minmax u_mm (
    .dbl(dbl_i), .is_max((op == OP_MAX) || (op == OP_MAXNM)),
    .x(mm_x), .y(mm_y), .res(mm_res)
  );

  // generated invalid cases
  logic prod_sign, prod_nan, gen_nan;

  always_comb begin
    prod_sign = cls[0].sign ^ cls[1].sign;
    prod_nan  = (cls[0].inf & cls[1].zero) | (cls[1].inf & cls[0].zero);
    unique case (op)
      OP_ADD:  gen_nan = cls[0].inf & cls[1].inf & (cls[0].sign ^ cls[1].sign);
      OP_SUB:  gen_nan = cls[0].inf & cls[1].inf & ~(cls[0].sign ^ cls[1].sign);
      OP_MUL:  gen_nan = prod_nan;
      OP_DIV:  gen_nan = (cls[0].inf & cls[1].inf) | (cls[0].zero & cls[1].zero);
      OP_SQRT: gen_nan = cls[0].sign & ~cls[0].zero & ~cls[0].nan;
      OP_FMA, OP_FMS, OP_FNMA, OP_FNMS:
        gen_nan = prod_nan |
                  (cls[2].inf & (cls[0].inf | cls[1].inf) & (cls[2].sign ^ prod_sign));
      default: gen_nan = 1'b0;
    endcase
  end

  // next-state decision
  logic          nx_special, nx_invalid;
  logic [DW-1:0] nx_result, proc_nan, dnan;

  always_comb begin
    dnan       = default_nan(dbl_i);
    proc_nan   = dn_mode_i ? dnan : (ord_val[nan_sel] | quiet_bit(dbl_i));
    nx_special = 1'b1;
    nx_invalid = 1'b0;
    nx_result  = '0;
    if (nm_sub) begin
      nx_result = mm_res;
    end else if (nan_found) begin
      if (is_fused && !snan_any && cls[2].nan && gen_nan) begin
        nx_result  = dnan;
        nx_invalid = 1'b1;
      end else begin
        nx_result  = proc_nan;
        nx_invalid = snan_any;
      end
    end else if (gen_nan) begin
      nx_result  = dnan;
      nx_invalid = 1'b1;
    end else if (is_mm) begin
      nx_result = mm_res;
    end else if (is_fused && (cls[0].zero | cls[1].zero) && cls[2].zero) begin
      nx_result = (cls[2].sign & prod_sign) ? sign_bit(dbl_i) : '0;
    end else begin
      nx_special = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
      special_o <= 1'b0;
      invalid_o <= 1'b0;
      result_o  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        special_o <= nx_special;
        invalid_o <= nx_invalid;
        result_o  <= nx_result;
      end
    end
  end
endmodule

// File: rtl/fpsr_checker.sv
module fpsr_checker
  import fpsr_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [OP_W-1:0] op_i,
  input logic            dbl_i,
  input logic            dn_mode_i,
  input logic            out_valid,
  input logic            special_o,
  input logic [DW-1:0]   result_o,
  input logic            invalid_o
);
  logic res_nan64;
  assign res_nan64 = (&result_o[DW-2:DP_FRAC]) && (|result_o[DP_FRAC-1:0]);

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_dn_pattern_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dn_mode_i && dbl_i) |=> (!special_o || !res_nan64 || result_o == default_nan(1'b1)));
  p_mm_resolved_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_i == 4'd5 || op_i == 4'd6)) |=> special_o);
  p_invalid_is_nan_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dbl_i) |=> (!invalid_o || (special_o && res_nan64)));
  p_upper_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dbl_i) |=> (result_o[DW-1:SP_W] == '0));
  p_plain_clear_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !special_o) |-> (result_o == '0 && !invalid_o));
endmodule

bind fp_special_resolver fpsr_checker u_fpsr_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_i(op_i), .dbl_i(dbl_i),
  .dn_mode_i(dn_mode_i), .out_valid(out_valid), .special_o(special_o),
  .result_o(result_o), .invalid_o(invalid_o)
);

// File: tb/fp_special_resolver_bench.sv
module fp_special_resolver_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  op;
  logic        dbl, dn;
  logic [63:0] a, b, c;
  logic        out_valid, special, invalid;
  logic [63:0] result;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fp_special_resolver u_fp_special_resolver (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_i(op), .dbl_i(dbl),
    .dn_mode_i(dn), .src_a_i(a), .src_b_i(b), .src_c_i(c),
    .out_valid(out_valid), .special_o(special), .result_o(result),
    .invalid_o(invalid)
  );

  // ---------------- behavioural reference ----------------
  function automatic logic [63:0] fx(input logic [63:0] x, input logic d);
    return d ? x : {32'h0, x[31:0]};
  endfunction
  function automatic logic sg(input logic [63:0] x, input logic d);
    return d ? x[63] : x[31];
  endfunction
  function automatic logic [62:0] mg(input logic [63:0] x, input logic d);
    return d ? x[62:0] : {32'h0, x[30:0]};
  endfunction
  function automatic logic nanp(input logic [63:0] x, input logic d);
    return d ? (x[62:52] == 11'h7FF && x[51:0] != 0) : (x[30:23] == 8'hFF && x[22:0] != 0);
  endfunction
  function automatic logic snanp(input logic [63:0] x, input logic d);
    return nanp(x, d) && !(d ? x[51] : x[22]);
  endfunction
  function automatic logic infp(input logic [63:0] x, input logic d);
    return d ? (x[62:0] == 63'h7FF0_0000_0000_0000) : (x[30:0] == 31'h7F80_0000);
  endfunction
  function automatic logic zerop(input logic [63:0] x, input logic d);
    return mg(x, d) == 0;
  endfunction
  function automatic logic lessp(input logic [63:0] x, input logic [63:0] y, input logic d);
    if (sg(x, d) != sg(y, d)) return sg(x, d);
    if (sg(x, d)) return mg(x, d) > mg(y, d);
    return mg(x, d) < mg(y, d);
  endfunction

  // returns {special, invalid, result}
  function automatic logic [65:0] ref_model(input logic [3:0] o, input logic d, input logic m,
                                            input logic [63:0] ia, input logic [63:0] ib,
                                            input logic [63:0] ic);
    logic [63:0] x, y, z, smask, dnan, qmask, pick;
    logic [63:0] seq [3];
    int cnt;
    logic found, sfound, gen, ps, ismax;
    x = fx(ia, d); y = fx(ib, d); z = fx(ic, d);
    smask = d ? 64'h8000_0000_0000_0000 : 64'h8000_0000;
    qmask = d ? 64'h0008_0000_0000_0000 : 64'h0040_0000;
    dnan  = d ? 64'h7FF8_0000_0000_0000 : 64'h7FC0_0000;
    if (o == 10 || o == 11) x = x ^ smask;
    if (o == 11 || o == 12) z = z ^ smask;
    ismax = (o == 5 || o == 7);
    if ((o == 7 || o == 8) && (nanp(x, d) != nanp(y, d)) && !snanp(x, d) && !snanp(y, d)) begin
      if (nanp(x, d)) x = (o == 7) ? (64'hFFF0_0000_0000_0000 & fx('1, d)) | (d ? 0 : 64'hFF80_0000) : (d ? 64'h7FF0_0000_0000_0000 : 64'h7F80_0000);
      if (nanp(y, d)) y = (o == 7) ? (d ? 64'hFFF0_0000_0000_0000 : 64'hFF80_0000) : (d ? 64'h7FF0_0000_0000_0000 : 64'h7F80_0000);
      if (!d && o == 7 && nanp(fx(ia, d), d)) x = 64'hFF80_0000;
      return {2'b10, (ismax ? (lessp(x, y, d) ? y : x) : (lessp(y, x, d) ? y : x))};
    end
    if (o >= 9)      begin seq[0] = z; seq[1] = x; seq[2] = y; cnt = 3; end
    else if (o == 4) begin seq[0] = x; seq[1] = 0; seq[2] = 0; cnt = 1; end
    else             begin seq[0] = x; seq[1] = y; seq[2] = 0; cnt = 2; end
    found = 0; sfound = 0; pick = 0;
    for (int k = cnt - 1; k >= 0; k--) if (nanp(seq[k], d)) begin found = 1; pick = seq[k]; end
    for (int k = cnt - 1; k >= 0; k--) if (snanp(seq[k], d)) begin sfound = 1; pick = seq[k]; end
    ps = sg(x, d) ^ sg(y, d);
    case (o)
      0: gen = infp(x, d) && infp(y, d) && sg(x, d) != sg(y, d);
      1: gen = infp(x, d) && infp(y, d) && sg(x, d) == sg(y, d);
      2: gen = (infp(x, d) && zerop(y, d)) || (infp(y, d) && zerop(x, d));
      3: gen = (infp(x, d) && infp(y, d)) || (zerop(x, d) && zerop(y, d));
      4: gen = sg(x, d) && !zerop(x, d) && !nanp(x, d);
      9, 10, 11, 12:
         gen = (infp(x, d) && zerop(y, d)) || (infp(y, d) && zerop(x, d)) ||
               (infp(z, d) && (infp(x, d) || infp(y, d)) && sg(z, d) != ps);
      default: gen = 0;
    endcase
    if (found) begin
      if (o >= 9 && !sfound && nanp(z, d) && gen) return {2'b11, dnan};
      return {1'b1, sfound, (m ? dnan : (pick | qmask))};
    end
    if (gen) return {2'b11, dnan};
    if (o >= 5 && o <= 8) return {2'b10, (ismax ? (lessp(x, y, d) ? y : x) : (lessp(y, x, d) ? y : x))};
    if (o >= 9 && (zerop(x, d) || zerop(y, d)) && zerop(z, d))
      return {2'b10, ((sg(z, d) && ps) ? smask : 64'h0)};
    return 66'h0;
  endfunction

  // ---------------- check helpers ----------------
  task automatic check(input string req, input string what, input logic [65:0] act, input logic [65:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual sp=%0b inv=%0b res=%h expected sp=%0b inv=%0b res=%h",
               req, what, act[65], act[64], act[63:0], exp[65], exp[64], exp[63:0]);
    end
  endtask

  task automatic drive(input logic [3:0] o, input logic d, input logic m,
                       input logic [63:0] ia, input logic [63:0] ib, input logic [63:0] ic);
    @(negedge clk);
    in_valid = 1'b1; op = o; dbl = d; dn = m; a = ia; b = ib; c = ic;
    @(posedge clk);
    #2;
  endtask

  // directed: hand expectation, also cross-checked against the reference
  task automatic dir(input string req, input logic [3:0] o, input logic d, input logic m,
                     input logic [63:0] ia, input logic [63:0] ib, input logic [63:0] ic,
                     input logic esp, input logic einv, input logic [63:0] eres);
    drive(o, d, m, ia, ib, ic);
    check(req, "valid", {65'h0, out_valid}, 66'h1);
    check(req, "directed", {special, invalid, result}, {esp, einv, eres});
    check(req, "model", {special, invalid, result}, ref_model(o, d, m, ia, ib, ic));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    #2;
    check("R1", "idle out_valid", {65'h0, out_valid}, 66'h0);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // operand pool for sweeping
  function automatic logic [63:0] pool(input int k, input logic d);
    if (d) case (k)
      0: return 64'h0; 1: return 64'h8000_0000_0000_0000;
      2: return 64'h7FF0_0000_0000_0000; 3: return 64'hFFF0_0000_0000_0000;
      4: return 64'h7FF8_0000_0000_1234; 5: return 64'hFFF8_0000_0000_00AB;
      6: return 64'h7FF0_0000_0000_5678; 7: return 64'hFFF0_0000_0000_0011;
      8: return 64'h3FF0_0000_0000_0000; 9: return 64'hC000_0000_0000_0000;
      10: return 64'h0000_0000_0000_0001; default: return 64'h7FEF_FFFF_FFFF_FFFF;
    endcase
    else case (k)
      0: return 64'h0; 1: return 64'hDEAD_0000_8000_0000;
      2: return 64'h7F80_0000; 3: return 64'hFF80_0000;
      4: return 64'h7FC0_1234; 5: return 64'h1234_5678_FFC0_0077;
      6: return 64'h7F80_5678; 7: return 64'hFF80_0011;
      8: return 64'h3F80_0000; 9: return 64'hC000_0000;
      10: return 64'h0000_0001; default: return 64'h7F7F_FFFF;
    endcase
  endfunction

  localparam logic [63:0] DN64 = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] DN32 = 64'h7FC0_0000;

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op = 0; dbl = 0; dn = 0; a = 0; b = 0; c = 0;
    repeat (3) @(posedge clk);
    #2;
    check("R1", "reset state", {special, invalid, 63'h0, out_valid}, 66'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    check("R1", "post-reset idle", {special, invalid, 63'h0, out_valid}, 66'h0);

    // R2 two-operand priority and quieting
    dir("R2", 0, 0, 0, 64'h7F80_1234, 64'h7FC0_5678, 0, 1, 1, 64'h7FC0_1234);
    dir("R2", 0, 0, 0, 64'h7FC0_1234, 64'h7F80_5678, 0, 1, 1, 64'h7FC0_5678);
    dir("R2", 2, 0, 0, 64'h3F80_0000, 64'hFFC0_0077, 0, 1, 0, 64'hFFC0_0077);
    dir("R2", 3, 0, 0, 64'h7FC0_1234, 64'hFFC0_0077, 0, 1, 0, 64'h7FC0_1234);
    dir("R2", 6, 0, 0, 64'h3F80_0000, 64'h7FC0_1234, 0, 1, 0, 64'h7FC0_1234);
    idle();
    // R3 fused priority C, A, B
    dir("R3", 9, 1, 0, 64'h7FF8_0000_0000_1234, 64'h7FF0_0000_0000_5678, 64'hFFF8_0000_0000_00AB, 1, 1, 64'h7FF8_0000_0000_5678);
    dir("R3", 9, 1, 0, 64'h7FF0_0000_0000_0011, 64'h7FF0_0000_0000_0022, 64'h3FF0_0000_0000_0000, 1, 1, 64'h7FF8_0000_0000_0011);
    dir("R3", 9, 1, 0, 64'h7FF8_0000_0000_1234, 64'h7FF8_0000_0000_5678, 64'hFFF8_0000_0000_00AB, 1, 0, 64'hFFF8_0000_0000_00AB);
    dir("R3", 9, 1, 0, 64'h7FF0_0000_0000_0011, 64'h3FF0_0000_0000_0000, 64'hFFF0_0000_0000_0099, 1, 1, 64'hFFF8_0000_0000_0099);
    // R4 default-NaN mode
    dir("R4", 0, 0, 1, 64'h7F80_1234, 64'h3F80_0000, 0, 1, 1, DN32);
    dir("R4", 2, 1, 1, 64'hFFF8_0000_0000_1234, 64'h3FF0_0000_0000_0000, 0, 1, 0, DN64);
    // R5 generated cases
    dir("R5", 0, 0, 0, 64'h7F80_0000, 64'hFF80_0000, 0, 1, 1, DN32);
    dir("R14", 0, 0, 0, 64'h7F80_0000, 64'h7F80_0000, 0, 0, 0, 0);
    dir("R5", 1, 1, 0, 64'h7FF0_0000_0000_0000, 64'h7FF0_0000_0000_0000, 0, 1, 1, DN64);
    dir("R5", 2, 0, 0, 64'h0, 64'hFF80_0000, 0, 1, 1, DN32);
    dir("R5", 3, 0, 0, 64'hFF80_0000, 64'h7F80_0000, 0, 1, 1, DN32);
    dir("R5", 3, 1, 0, 64'h0, 64'h8000_0000_0000_0000, 0, 1, 1, DN64);
    dir("R14", 3, 0, 0, 64'h3F80_0000, 64'h0, 0, 0, 0, 0);
    // R6 sqrt
    dir("R6", 4, 0, 0, 64'hC000_0000, 0, 0, 1, 1, DN32);
    dir("R6", 4, 0, 0, 64'h8000_0000, 0, 0, 0, 0, 0);
    dir("R6", 4, 0, 0, 64'hFF80_0000, 0, 0, 1, 1, DN32);
    dir("R6", 4, 0, 0, 64'hFFC0_0077, 64'h7F80_0001, 0, 1, 0, 64'hFFC0_0077);
    idle();
    // R7 fused generated NaN
    dir("R7", 9, 1, 0, 64'h7FF0_0000_0000_0000, 64'h0, 64'h7FF8_0000_0000_1234, 1, 1, DN64);
    dir("R7", 9, 1, 0, 64'hFFF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, 64'h7FF0_0000_0000_0000, 1, 1, DN64);
    dir("R7", 9, 1, 0, 64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, 64'h7FF8_0000_0000_1234, 1, 0, 64'h7FF8_0000_0000_1234);
    // R8 number-preferring
    dir("R8", 7, 0, 0, 64'h7FC0_1234, 64'h3F80_0000, 0, 1, 0, 64'h3F80_0000);
    dir("R8", 8, 0, 0, 64'hC000_0000, 64'h7FC0_1234, 0, 1, 0, 64'hC000_0000);
    dir("R8", 7, 0, 0, 64'h7FC0_1234, 64'hFF80_0000, 0, 1, 0, 64'hFF80_0000);
    dir("R8", 8, 1, 0, 64'h7FF8_0000_0000_1234, 64'h7FF0_0000_0000_0000, 0, 1, 0, 64'h7FF0_0000_0000_0000);
    dir("R8", 7, 0, 0, 64'h7F80_1234, 64'h3F80_0000, 0, 1, 1, 64'h7FC0_1234);
    dir("R8", 7, 0, 0, 64'h7FC0_1234, 64'hFFC0_0077, 0, 1, 0, 64'h7FC0_1234);
    // R9 max/min and signed zeros
    dir("R9", 5, 0, 0, 64'h0, 64'h8000_0000, 0, 1, 0, 64'h0);
    dir("R9", 5, 0, 0, 64'h8000_0000, 64'h0, 0, 1, 0, 64'h0);
    dir("R9", 6, 0, 0, 64'h0, 64'h8000_0000, 0, 1, 0, 64'h8000_0000);
    dir("R9", 6, 0, 0, 64'h8000_0000, 64'h0, 0, 1, 0, 64'h8000_0000);
    dir("R9", 5, 0, 0, 64'h3F80_0000, 64'hC000_0000, 0, 1, 0, 64'h3F80_0000);
    dir("R9", 5, 1, 0, 64'hBFF0_0000_0000_0000, 64'hC000_0000_0000_0000, 0, 1, 0, 64'hBFF0_0000_0000_0000);
    // R10 exact-zero sign
    dir("R10", 9, 1, 0, 64'h0, 64'hBFF0_0000_0000_0000, 64'h8000_0000_0000_0000, 1, 0, 64'h8000_0000_0000_0000);
    dir("R10", 9, 1, 0, 64'h0, 64'h3FF0_0000_0000_0000, 64'h8000_0000_0000_0000, 1, 0, 64'h0);
    dir("R10", 10, 1, 0, 64'h0, 64'h3FF0_0000_0000_0000, 64'h8000_0000_0000_0000, 1, 0, 64'h8000_0000_0000_0000);
    // R11 invalid on sNaN into max
    dir("R11", 5, 0, 0, 64'h3F80_0000, 64'hFF80_0011, 0, 1, 1, 64'hFFC0_0011);
    // R12 upper bits ignored in binary32
    dir("R12", 0, 0, 0, 64'hFFFF_FFFF_7F80_1234, 64'hAAAA_5555_3F80_0000, 0, 1, 1, 64'h7FC0_1234);
    // R13 negated fused forms
    dir("R13", 11, 1, 0, 64'h7FF8_0000_0000_1234, 64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1, 0, 64'hFFF8_0000_0000_1234);
    dir("R13", 12, 1, 0, 64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, 64'hFFF8_0000_0000_00AB, 1, 0, 64'h7FF8_0000_0000_00AB);
    dir("R13", 10, 1, 0, 64'h7FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, 64'h7FF0_0000_0000_0000, 1, 1, DN64);
    // R14 ordinary operands
    dir("R14", 0, 1, 0, 64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, 0, 0, 0, 0);
    dir("R14", 9, 0, 0, 64'h3F80_0000, 64'hC000_0000, 64'h0000_0001, 0, 0, 0);
    idle();

    // sweep against the reference model, every clock
    for (int it = 0; it < 4000; it++) begin
      logic [3:0] o;
      logic d, m;
      logic [63:0] ia, ib, ic;
      o  = 4'($urandom_range(0, 12));
      d  = 1'($urandom_range(0, 1));
      m  = ($urandom_range(0, 3) == 0);
      ia = pool($urandom_range(0, 11), d);
      ib = pool($urandom_range(0, 11), d);
      ic = pool($urandom_range(0, 11), d);
      drive(o, d, m, ia, ib, ic);
      check("R11", "sweep vs model", {special, invalid, result}, ref_model(o, d, m, ia, ib, ic));
      if (it % 97 == 0) idle();
    end
    idle();
    report();
  end
endmodule